// File: doc/BRIEF.md
# Serial Receiver with Address-Marked Word Filtering

This block receives asynchronous serial words of either eight or nine data bits, least significant bit first, framed by one low start bit and one high stop bit. The line is first brought into the clock domain through a short synchronizer chain. It is then timed against an external tick that runs at sixteen times the bit rate. Each bit, including the start and stop bits, is read once near its centre. A finished word is moved into a holding register and raises a data-ready flag, which stays up until the consumer pulses a read strobe.

For shared buses where several receivers listen to one line, the block can filter its interrupt request. When filtering is on, every word still lands in the holding register and still raises the ready flag. The interrupt is pended only if the word's most significant received bit is 1, which marks the word as an address. That bit is bit 8 for nine-bit words and bit 7 for eight-bit words. When filtering is off, every word pends the interrupt. The pending request reaches the output only while both the local and the global interrupt enables are high.

An optional even-parity check treats the last received bit as the parity bit. Parity and address filtering exclude each other: with filtering on, the top bit is always the address marker and the parity result is forced clear. The block also flags a low stop bit, rejects start bits that do not last to their midpoint, and reports an overrun when a word completes while the previous one is still unread.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, data_o is 0 and avail_o, irq_o, overrun_o, frame_err_o and parity_err_o are all low.
- R2: A word is received least significant bit first. Its length is set by nine_bit_i as sampled at the start bit: 9 bits when 1, 8 bits when 0. In 8-bit mode, data_o[8] reads 0.
- R3: avail_o rises when a word completes and falls on the cycle after a rd_pulse_i that does not coincide with a completion.
- R4: With addr_det_en_i low, every completed word pends the interrupt, whatever its top bit is.
- R5: With addr_det_en_i high, a completed word pends the interrupt only if its top bit is 1. The top bit is bit 8 in 9-bit mode and bit 7 in 8-bit mode. A word whose top bit is 0 leaves the request unpended.
- R6: irq_o is high exactly when an interrupt is pending and both per_ie_i and glob_ie_i are high. A pending interrupt is cleared by rd_pulse_i.
- R7: With parity_en_i high and addr_det_en_i low, parity_err_o is set for a word whose bits (the parity bit included) have an odd count of ones, and cleared otherwise. With addr_det_en_i high, parity_err_o is 0 after every word.
- R8: A start bit that reads high at its midpoint is discarded. No word completes, and the receiver waits for the next falling edge.
- R9: frame_err_o is set with a word whose stop bit reads low, and cleared with a word whose stop bit reads high.
- R10: overrun_o is set when a word completes while avail_o is still high, and is cleared by rd_pulse_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| tick_i | input | 1 | One-cycle strobe at 16 times the bit rate |
| nine_bit_i | input | 1 | 1 selects 9-bit words, 0 selects 8-bit words |
| addr_det_en_i | input | 1 | Enables interrupt filtering on the top bit |
| parity_en_i | input | 1 | Enables even-parity check of the last bit |
| per_ie_i | input | 1 | Receiver interrupt enable |
| glob_ie_i | input | 1 | Global interrupt enable |
| rd_pulse_i | input | 1 | Read strobe; clears ready, overrun and pending interrupt |
| data_o | output | 9 | Last received word, zero-extended in 8-bit mode |
| avail_o | output | 1 | Received word is waiting to be read |
| irq_o | output | 1 | Interrupt request |
| overrun_o | output | 1 | A word arrived while the previous one was unread |
| frame_err_o | output | 1 | Stop bit of the last word read low |
| parity_err_o | output | 1 | Parity of the last word was odd |

## Verification
Random words are sent across all combinations of word length, filter enable and the two interrupt enables. With filtering on, a word whose top bit is 1 and a word whose top bit is 0 must behave differently. Directed words put a 1 in bit 7 of a nine-bit word and in bit 8 of an eight-bit word; these show whether the address marker is taken from the right bit position. Parity runs with odd and even payloads separate a real check from a stuck flag, and the same payloads with filtering on confirm that the parity flag is suppressed. A short low pulse, a low stop bit and two unread words in a row exercise the glitch, framing and overrun paths.

// File: rtl/uart_rx_pkg.sv
// Package: shared types for the address-filtering serial receiver.
// Assumes: none; holds only the framer state encoding.
package uart_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

endpackage

// File: rtl/rx_sync.sv
// Module: rx_sync
// Brings the asynchronous serial line into the clock domain through a chain
// of flops. Assumes the line idles high, so every stage resets to 1.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // single-stage capture
            always_ff @(posedge clk_i) begin
                if (!rst_ni) chain_q <= 1'b1;
                else         chain_q <= async_i;
            end
        end else begin : g_multi
            // shift the line value along the chain
            always_ff @(posedge clk_i) begin
                if (!rst_ni) chain_q <= '1;
                else         chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/rx_framer.sv
// Module: rx_framer
// Detects a start bit, times each bit with the oversampling tick, reads
// every bit once at its centre and assembles the word LSB first.
// Assumes: tick_i is a one-cycle strobe at OVS times the bit rate, and the
// synchronized line idles high. The word length is latched at start
// detection, so a change in nine_bit_i mid-word does not disturb that word.
module rx_framer
    import uart_rx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              rx_s_i,
    input  logic              nine_bit_i,
    output logic              done_o,
    output logic [DATA_W-1:0] word_o,
    output logic              word_nine_o,
    output logic              stop_bad_o
);

    localparam int              CW        = $clog2(OVS);
    localparam int              IW        = $clog2(DATA_W + 1);
    localparam logic [CW-1:0]   CNT_MID   = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0]   CNT_LAST  = CW'(OVS - 1);
    localparam logic [IW-1:0]   IDX_LONG  = IW'(DATA_W - 1);
    localparam logic [IW-1:0]   IDX_SHORT = IW'(DATA_W - 2);

    rx_state_t         state_q;
    logic [CW-1:0]     cnt_q;
    logic [IW-1:0]     idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              nine_q;
    logic [IW-1:0]     idx_end;

    // last bit index of the word being received
    always_comb begin
        idx_end = nine_q ? IDX_LONG : IDX_SHORT;
    end

    // bit timing, sampling and word hand-off
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q     <= RX_IDLE;
            cnt_q       <= '0;
            idx_q       <= '0;
            shreg_q     <= '0;
            nine_q      <= 1'b0;
            done_o      <= 1'b0;
            word_o      <= '0;
            word_nine_o <= 1'b0;
            stop_bad_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    if (tick_i && !rx_s_i) begin
                        state_q <= RX_START;
                        cnt_q   <= '0;
                        nine_q  <= nine_bit_i;
                    end
                end
                RX_START: begin
                    if (tick_i) begin
                        if (cnt_q == CNT_MID) begin
                            cnt_q <= '0;
                            if (!rx_s_i) begin
                                state_q <= RX_DATA;
                                idx_q   <= '0;
                                shreg_q <= '0;
                            end else begin
                                state_q <= RX_IDLE;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick_i) begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q          <= '0;
                            shreg_q[idx_q] <= rx_s_i;
                            if (idx_q == idx_end) state_q <= RX_STOP;
                            else                  idx_q   <= idx_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick_i) begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q       <= '0;
                            state_q     <= RX_IDLE;
                            done_o      <= 1'b1;
                            word_o      <= shreg_q;
                            word_nine_o <= nine_q;
                            stop_bad_o  <= !rx_s_i;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rx_qualify.sv
// Module: rx_qualify
// Holds the last word and its status, and decides whether a completed word
// pends the interrupt. Assumes done_i is a one-cycle pulse carrying a
// finished word. A completion takes priority over a read in the same cycle.
module rx_qualify #(
    parameter int DATA_W = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              done_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              word_nine_i,
    input  logic              stop_bad_i,
    input  logic              addr_det_en_i,
    input  logic              parity_en_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              avail_o,
    output logic              overrun_o,
    output logic              frame_err_o,
    output logic              parity_err_o,
    output logic              pend_o
);

    logic top_bit;
    logic qualifies;
    logic odd_ones;

    // choose the address marker and work out qualification and parity
    always_comb begin
        top_bit   = word_nine_i ? word_i[DATA_W-1] : word_i[DATA_W-2];
        qualifies = !addr_det_en_i || top_bit;
        odd_ones  = ^word_i;
    end

    // register the word, its status flags and the pending request
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            data_o       <= '0;
            avail_o      <= 1'b0;
            overrun_o    <= 1'b0;
            frame_err_o  <= 1'b0;
            parity_err_o <= 1'b0;
            pend_o       <= 1'b0;
        end else if (done_i) begin
            data_o       <= word_i;
            avail_o      <= 1'b1;
            overrun_o    <= (overrun_o || avail_o) && !rd_i;
            frame_err_o  <= stop_bad_i;
            parity_err_o <= parity_en_i && !addr_det_en_i && odd_ones;
            pend_o       <= (pend_o && !rd_i) || qualifies;
        end else if (rd_i) begin
            avail_o   <= 1'b0;
            overrun_o <= 1'b0;
            pend_o    <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_addr_rx.sv
// Module: uart_addr_rx
// Top of the serial receiver with address-marked interrupt filtering.
// Assumes: tick_i comes from an external baud generator at OVS times the
// bit rate. Parity and address filtering are exclusive: with filtering on,
// the top bit is the address marker and the parity flag stays clear.
module uart_addr_rx #(
    parameter int OVS         = 16,
    parameter int DATA_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rx_i,
    input  logic              tick_i,
    input  logic              nine_bit_i,
    input  logic              addr_det_en_i,
    input  logic              parity_en_i,
    input  logic              per_ie_i,
    input  logic              glob_ie_i,
    input  logic              rd_pulse_i,
    output logic [DATA_W-1:0] data_o,
    output logic              avail_o,
    output logic              irq_o,
    output logic              overrun_o,
    output logic              frame_err_o,
    output logic              parity_err_o
);

    logic              rx_s;
    logic              w_done;
    logic [DATA_W-1:0] w_word;
    logic              w_nine;
    logic              w_stop_bad;
    logic              w_pend;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (rx_i),
        .sync_o  (rx_s)
    );

    rx_framer #(.OVS(OVS), .DATA_W(DATA_W)) u_framer (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick_i),
        .rx_s_i      (rx_s),
        .nine_bit_i  (nine_bit_i),
        .done_o      (w_done),
        .word_o      (w_word),
        .word_nine_o (w_nine),
        .stop_bad_o  (w_stop_bad)
    );

    rx_qualify #(.DATA_W(DATA_W)) u_qual (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .done_i        (w_done),
        .word_i        (w_word),
        .word_nine_i   (w_nine),
        .stop_bad_i    (w_stop_bad),
        .addr_det_en_i (addr_det_en_i),
        .parity_en_i   (parity_en_i),
        .rd_i          (rd_pulse_i),
        .data_o        (data_o),
        .avail_o       (avail_o),
        .overrun_o     (overrun_o),
        .frame_err_o   (frame_err_o),
        .parity_err_o  (parity_err_o),
        .pend_o        (w_pend)
    );

    // request leaves the block only while both enables are set
    always_comb begin
        irq_o = w_pend && per_ie_i && glob_ie_i;
    end

endmodule

// File: rtl/uart_addr_rx_chk.sv
// Module: uart_addr_rx_chk
// Checker for uart_addr_rx, attached by the bind statement below. It
// watches the ports and the hand-off between framer and status stage.
module uart_addr_rx_chk #(
    parameter int DATA_W = 9
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              rd_pulse_i,
    input logic              addr_det_en_i,
    input logic              w_done,
    input logic [DATA_W-1:0] w_word,
    input logic              w_nine,
    input logic              w_pend,
    input logic [DATA_W-1:0] data_o,
    input logic              avail_o,
    input logic              irq_o,
    input logic              overrun_o,
    input logic              parity_err_o
);

    logic marker;

    // address marker of the word being handed over
    always_comb begin
        marker = w_nine ? w_word[DATA_W-1] : w_word[DATA_W-2];
    end

    // R3: a lone read strobe empties the holding register
    a_r3_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_pulse_i && !w_done) |=> !avail_o);

    // R10: overrun only appears when a word was already waiting
    a_r10_overrun_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(overrun_o) |-> $past(avail_o));

    // R5: a data word never pends the request while filtering is on
    a_r5_data_word_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_det_en_i && w_done && !marker && !w_pend) |=> !w_pend);

    // R7: parity result is suppressed while filtering is on
    a_r7_no_parity_with_filter: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_det_en_i && w_done) |=> !parity_err_o);

    // R2: an eight-bit word leaves the ninth bit clear
    a_r2_short_word_top_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (w_done && !w_nine) |=> !data_o[DATA_W-1]);

    // R6: a request is only ever raised for a word that is still waiting
    a_r6_irq_implies_avail: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> avail_o);

endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_pulse_i    (rd_pulse_i),
    .addr_det_en_i (addr_det_en_i),
    .w_done        (w_done),
    .w_word        (w_word),
    .w_nine        (w_nine),
    .w_pend        (w_pend),
    .data_o        (data_o),
    .avail_o       (avail_o),
    .irq_o         (irq_o),
    .overrun_o     (overrun_o),
    .parity_err_o  (parity_err_o)
);

// File: tb/sim_uart_addr_rx.sv
`timescale 1ns/1ps
module sim_uart_addr_rx;

    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic       nine = 1'b0;
    logic       addr_en = 1'b0;
    logic       par_en = 1'b0;
    logic       pie = 1'b0;
    logic       gie = 1'b0;
    logic       rd = 1'b0;
    logic [8:0] data;
    logic       avail, irq, ovr, ferr, perr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int tick_cnt = 0;

    always #2.5 clk = ~clk;

    // oversampling tick: one cycle in TICK_DIV
    always @(posedge clk) begin
        tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
        tick     <= (tick_cnt == TICK_DIV - 1);
    end

    uart_addr_rx u0 (
        .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick_i(tick),
        .nine_bit_i(nine), .addr_det_en_i(addr_en), .parity_en_i(par_en),
        .per_ie_i(pie), .glob_ie_i(gie), .rd_pulse_i(rd),
        .data_o(data), .avail_o(avail), .irq_o(irq), .overrun_o(ovr),
        .frame_err_o(ferr), .parity_err_o(perr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_data(input logic [8:0] w, input logic n9);
        return n9 ? w : {1'b0, w[7:0]};
    endfunction

    function automatic logic exp_irq(input logic [8:0] w, input logic n9,
                                     input logic ad, input logic pi, input logic gi);
        logic top;
        top = n9 ? w[8] : w[7];
        return (!ad || top) && pi && gi;
    endfunction

    function automatic logic exp_perr(input logic [8:0] w, input logic n9,
                                      input logic ad, input logic pe);
        return pe && !ad && (^exp_data(w, n9));
    endfunction

    // drive one frame on the line, LSB first
    task automatic send(input logic [8:0] w, input logic n9, input logic stop_hi);
        rx = 1'b0;
        repeat (BIT_CLKS) @(posedge clk);
        for (int i = 0; i < (n9 ? 9 : 8); i++) begin
            rx = w[i];
            repeat (BIT_CLKS) @(posedge clk);
        end
        rx = stop_hi;
        repeat (BIT_CLKS) @(posedge clk);
        rx = 1'b1;
        repeat (BIT_CLKS) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_pulse();
        @(negedge clk) rd = 1'b1;
        @(negedge clk) rd = 1'b0;
    endtask

    // one full word with configuration, checks and read-back
    task automatic frame(input logic [8:0] w, input logic n9, input logic ad,
                         input logic pe, input logic pi, input logic gi);
        @(negedge clk);
        nine = n9; addr_en = ad; par_en = pe; pie = pi; gie = gi;
        send(w, n9, 1'b1);
        chk(data == exp_data(w, n9), "R2 data", data, exp_data(w, n9));
        chk(avail == 1'b1, "R3 avail set", avail, 1);
        chk(irq == exp_irq(w, n9, ad, pi, gi), ad ? "R5 filtered irq" : "R4 irq", irq,
            exp_irq(w, n9, ad, pi, gi));
        chk(perr == exp_perr(w, n9, ad, pe), "R7 parity", perr, exp_perr(w, n9, ad, pe));
        chk(ferr == 1'b0, "R9 good stop", ferr, 0);
        chk(ovr == 1'b0, "R10 no overrun", ovr, 0);
        read_pulse();
        chk(avail == 1'b0, "R3 read clears", avail, 0);
        chk(irq == 1'b0, "R6 read clears irq", irq, 0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(data == 9'd0 && !avail && !irq && !ovr && !ferr && !perr,
            "R1 reset state", {avail, irq, ovr, ferr, perr, data}, 0);
        rst_n = 1'b1;
        repeat (8) @(posedge clk);

        // R5: marker position follows the word length
        frame(9'h080, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);  // bit 7 set, 9-bit: data
        frame(9'h100, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);  // bit 8 ignored, 8-bit: data
        frame(9'h080, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);  // 8-bit address
        frame(9'h155, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);  // 9-bit address
        // R4: low top bit still interrupts without filtering
        frame(9'h013, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        // R6: each enable alone blocks the request
        frame(9'h1FF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        frame(9'h1FF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        // R7: odd and even payloads, then with filtering on
        frame(9'h001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        frame(9'h003, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        frame(9'h181, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);

        // R8: short low pulse is rejected
        @(negedge clk) rx = 1'b0;
        repeat (8) @(posedge clk);
        rx = 1'b1;
        repeat (4 * BIT_CLKS) @(posedge clk);
        @(negedge clk);
        chk(avail == 1'b0, "R8 glitch ignored", avail, 0);
        frame(9'h0A5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);

        // R9: low stop bit
        send(9'h03C, 1'b0, 1'b0);
        repeat (2 * BIT_CLKS) @(posedge clk);
        @(negedge clk);
        chk(ferr == 1'b1, "R9 framing error", ferr, 1);
        chk(data == 9'h03C, "R9 word kept", data, 9'h03C);
        read_pulse();

        // R10: two words without a read
        send(9'h011, 1'b0, 1'b1);
        chk(ovr == 1'b0, "R10 first word", ovr, 0);
        send(9'h022, 1'b0, 1'b1);
        chk(ovr == 1'b1, "R10 overrun set", ovr, 1);
        chk(data == 9'h022, "R10 newest word", data, 9'h022);
        read_pulse();
        chk(ovr == 1'b0 && avail == 1'b0, "R10 read clears", {ovr, avail}, 0);

        // random mix of words and configurations
        for (int k = 0; k < 30; k++) begin
            logic [8:0] w;
            logic [5:0] cfg;
            w   = 9'($urandom);
            cfg = 6'($urandom);
            frame(w, cfg[0], cfg[1], cfg[2], cfg[3] | cfg[5], cfg[4] | cfg[5]);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule